// File: doc/BRIEF.md
# Packed leading-bit counting unit

This unit counts how many bits at the top of a 32-bit operand repeat the same value. It offers three count kinds: a run of zeros, a run of ones, and a run of redundant sign bits. The sign count is the number of bits below the most significant bit that equal it, so the sign bit itself is never counted. The output is driven combinationally from the inputs and is ready in the same cycle, with no clock and no stored state.

The unit works at one of two widths. In word mode the whole operand is one lane and the count goes into the low bits of the result. In halfword mode bits 15:0 and bits 31:16 are counted as separate lanes. The count for the low lane goes into result bits 15:0 and the count for the high lane goes into bits 31:16. Each lane's count stops at the width of that lane.

Top module: `lbc_unit`

## Requirements
- R1: With kind_i = 2'b00 and half_i = 0, the result is the number of consecutive zero bits starting at bit 31.
- R2: With kind_i = 2'b01 and half_i = 0, the result is the number of consecutive one bits starting at bit 31.
- R3: With kind_i = 2'b10 and half_i = 0, the result is the number of bits from bit 30 downward that equal bit 31, counted until the first bit that differs. The result is never more than 31.
- R4: In word mode, an all-zero operand counted for zeros gives 32, and an all-ones operand counted for ones gives 32.
- R5: With half_i = 1, result[15:0] is the count for operand bits 15:0 and result[31:16] is the count for operand bits 31:16. The two lanes are counted separately, and a run never carries over from bit 16 into bit 15.
- R6: With half_i = 1 and kind_i = 2'b00 or 2'b01, the count for each lane is at most 16, and a lane whose 16 bits all match gives 16.
- R7: With half_i = 1 and kind_i = 2'b10, the count for each lane excludes the lane's own top bit and is at most 15. A lane that is all zeros or all ones gives 15.
- R8: kind_i = 2'b11 is reserved and gives a result of zero in both modes.
- R9: The result follows every change of operand_i, kind_i or half_i without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | 32 | Value to be counted |
| kind_i | input | 2 | Count kind: 00 zeros, 01 ones, 10 redundant sign bits, 11 reserved |
| half_i | input | 1 | 0 counts one 32-bit lane, 1 counts two 16-bit lanes |
| result_o | output | 32 | Count, or two packed lane counts in halfword mode |

## Verification
In halfword mode both lanes produce counts in the same evaluation, and a fault in one lane can spill into the other lane or hide behind it. The bench provokes this with operands where the run in the high lane reaches bit 16 while the low lane starts with a value that would extend the run. It also uses operands where both lanes saturate together. Each 16-bit field of the result is compared separately with a reference count that the bench computes for that lane alone.

// File: rtl/lbc_pkg.sv
package lbc_pkg;
    typedef enum logic [1:0] {
        KIND_ZEROS = 2'b00,
        KIND_ONES  = 2'b01,
        KIND_SIGN  = 2'b10,
        KIND_RSVD  = 2'b11
    } lbc_kind_e;
endpackage

// File: rtl/lbc_run_len.sv
// Length of the run of bits equal to match_i, starting at the top bit.
module lbc_run_len #(
    parameter int W  = 16,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  bits_i,
    input  logic          match_i,
    output logic [CW-1:0] len_o
);
    logic stop;

    always_comb begin
        len_o = '0;
        stop  = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!stop && (bits_i[i] == match_i)) begin
                len_o = len_o + CW'(1);
            end else begin
                stop = 1'b1;
            end
        end
    end
endmodule

// File: rtl/lbc_lane.sv
// One counting lane: picks the count for the requested kind.
module lbc_lane
    import lbc_pkg::*;
#(
    parameter int W  = 16,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  data_i,
    input  lbc_kind_e     kind_i,
    output logic [CW-1:0] cnt_o
);
    logic [CW-1:0] zero_len;
    logic [CW-1:0] one_len;

    lbc_run_len #(.W(W), .CW(CW)) i_zero_run (
        .bits_i (data_i),
        .match_i(1'b0),
        .len_o  (zero_len)
    );

    lbc_run_len #(.W(W), .CW(CW)) i_one_run (
        .bits_i (data_i),
        .match_i(1'b1),
        .len_o  (one_len)
    );

    // The run that matches the top bit is at least one long, so
    // subtracting one can never wrap.
    always_comb begin
        unique case (kind_i)
            KIND_ZEROS: cnt_o = zero_len;
            KIND_ONES:  cnt_o = one_len;
            KIND_SIGN:  cnt_o = data_i[W-1] ? (one_len - CW'(1))
                                            : (zero_len - CW'(1));
            default:    cnt_o = '0;
        endcase
    end
endmodule

// File: rtl/lbc_unit.sv
module lbc_unit
    import lbc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = 2
) (
    input  logic [31:0] operand_i,
    input  logic [1:0]  kind_i,
    input  logic        half_i,
    output logic [31:0] result_o
);
    localparam int LANE_W = DATA_W / LANES;
    localparam int WCW    = $clog2(DATA_W + 1);
    localparam int LCW    = $clog2(LANE_W + 1);

    lbc_kind_e         kind;
    logic [WCW-1:0]    word_cnt;
    logic [DATA_W-1:0] word_res;
    logic [DATA_W-1:0] half_res;

    assign kind = lbc_kind_e'(kind_i);

    lbc_lane #(.W(DATA_W), .CW(WCW)) i_word_lane (
        .data_i(operand_i),
        .kind_i(kind),
        .cnt_o (word_cnt)
    );

    assign word_res = DATA_W'(word_cnt);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LCW-1:0] lane_cnt;

        lbc_lane #(.W(LANE_W), .CW(LCW)) i_half_lane (
            .data_i(operand_i[l*LANE_W +: LANE_W]),
            .kind_i(kind),
            .cnt_o (lane_cnt)
        );

        assign half_res[l*LANE_W +: LANE_W] = LANE_W'(lane_cnt);
    end

    assign result_o = half_i ? half_res : word_res;
endmodule

// File: rtl/lbc_unit_chk.sv
module lbc_unit_chk (
    input logic [31:0] operand_i,
    input logic [1:0]  kind_i,
    input logic        half_i,
    input logic [31:0] result_o
);
    logic [4:0] edge_idx;
    logic       known;

    always_comb begin
        known    = !$isunknown({operand_i, kind_i, half_i, result_o});
        edge_idx = 5'd31 - result_o[4:0];
        if (known) begin
            // R8
            rsvd_zero_chk: assert (kind_i != 2'b11 || result_o == 32'd0);
            // R3
            word_sign_cap_chk: assert (half_i || kind_i != 2'b10 || result_o <= 32'd31);
            // R6
            half_cap_chk: assert (!half_i || kind_i[1]
                || (result_o[15:0] <= 16'd16 && result_o[31:16] <= 16'd16));
            // R7
            half_sign_cap_chk: assert (!half_i || kind_i != 2'b10
                || (result_o[15:0] <= 16'd15 && result_o[31:16] <= 16'd15));
            // R1
            word_zero_edge_chk: assert (half_i || kind_i != 2'b00
                || result_o == 32'd32 || (result_o < 32'd32 && operand_i[edge_idx]));
            // R2
            word_one_edge_chk: assert (half_i || kind_i != 2'b01
                || result_o == 32'd32 || (result_o < 32'd32 && !operand_i[edge_idx]));
        end
    end
endmodule

bind lbc_unit lbc_unit_chk i_lbc_unit_chk (
    .operand_i(operand_i),
    .kind_i   (kind_i),
    .half_i   (half_i),
    .result_o (result_o)
);

// File: tb/test_lbc_unit.sv
module test_lbc_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic [31:0] operand;
    logic [1:0]  kind;
    logic        half;
    logic [31:0] result;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lbc_unit i_lbc_unit (
        .operand_i(operand),
        .kind_i   (kind),
        .half_i   (half),
        .result_o (result)
    );

    function automatic int run_of(logic [31:0] v, int top, logic b);
        int n = 0;
        for (int i = top; i >= 0; i--) begin
            if (v[i] == b) n++;
            else break;
        end
        return n;
    endfunction

    function automatic int lane_ref(logic [31:0] v, int w, logic [1:0] k);
        case (k)
            2'b00:   return run_of(v, w - 1, 1'b0);
            2'b01:   return run_of(v, w - 1, 1'b1);
            2'b10:   return run_of(v, w - 2, v[w-1]);
            default: return 0;
        endcase
    endfunction

    function automatic logic [31:0] model(logic [31:0] v, logic [1:0] k, logic h);
        logic [31:0] r;
        if (h) begin
            r[15:0]  = 16'(lane_ref({16'd0, v[15:0]}, 16, k));
            r[31:16] = 16'(lane_ref({16'd0, v[31:16]}, 16, k));
        end else begin
            r = 32'(lane_ref(v, 32, k));
        end
        return r;
    endfunction

    task automatic check(string req, logic [31:0] v, logic [1:0] k, logic h);
        logic [31:0] exp;
        operand = v; kind = k; half = h;
        #1;
        exp = model(v, k, h);
        n_run++;
        if (result !== exp) begin
            n_fail++;
            $display("FAIL %s op=%h kind=%0d half=%0d got=%h exp=%h",
                     req, v, k, h, result, exp);
        end
    endtask

    task automatic t_start;
        check("R4", 32'h0, 2'b00, 1'b0);
    endtask

    task automatic t_word_zeros;
        check("R1", 32'h0000_0001, 2'b00, 1'b0);
        check("R1", 32'h8000_0000, 2'b00, 1'b0);
        check("R1", 32'h0001_FFFF, 2'b00, 1'b0);
    endtask

    task automatic t_word_ones;
        check("R2", 32'hFFFF_FFFE, 2'b01, 1'b0);
        check("R2", 32'h7FFF_FFFF, 2'b01, 1'b0);
        check("R2", 32'hFFF0_0FFF, 2'b01, 1'b0);
    endtask

    task automatic t_word_sign;
        check("R3", 32'h0000_0000, 2'b10, 1'b0);
        check("R3", 32'hFFFF_FFFF, 2'b10, 1'b0);
        check("R3", 32'hC000_0000, 2'b10, 1'b0);
        check("R3", 32'h4000_0000, 2'b10, 1'b0);
        check("R3", 32'h0000_8000, 2'b10, 1'b0);
    endtask

    task automatic t_word_extremes;
        check("R4", 32'hFFFF_FFFF, 2'b01, 1'b0);
        check("R4", 32'h0000_0000, 2'b00, 1'b0);
        check("R4", 32'hFFFF_FFFF, 2'b00, 1'b0);
    endtask

    task automatic t_half_lanes;
        check("R5", 32'h0000_0001, 2'b00, 1'b1);
        check("R5", 32'h0001_8000, 2'b00, 1'b1);
        check("R5", 32'hFFFF_7FFF, 2'b01, 1'b1);
        check("R5", 32'h00F0_0F00, 2'b00, 1'b1);
    endtask

    task automatic t_half_saturate;
        check("R6", 32'h0000_0000, 2'b00, 1'b1);
        check("R6", 32'hFFFF_FFFF, 2'b01, 1'b1);
        check("R6", 32'h0000_FFFF, 2'b01, 1'b1);
    endtask

    task automatic t_half_sign;
        check("R7", 32'h0000_FFFF, 2'b10, 1'b1);
        check("R7", 32'hFFFF_0000, 2'b10, 1'b1);
        check("R7", 32'h3FFF_C001, 2'b10, 1'b1);
    endtask

    task automatic t_reserved;
        check("R8", 32'h1234_5678, 2'b11, 1'b0);
        check("R8", 32'h0000_0000, 2'b11, 1'b1);
    endtask

    task automatic t_no_clock;
        @(negedge clk);
        #1;
        check("R9", 32'h00FF_0000, 2'b00, 1'b0);
        check("R9", 32'h00FF_0000, 2'b00, 1'b1);
        check("R9", 32'h00FF_0000, 2'b01, 1'b1);
    endtask

    task automatic t_random;
        for (int i = 0; i < 300; i++) begin
            logic [31:0] v;
            v = $urandom;
            v = v >> (i % 32);
            if (i[0]) v = ~v;
            check("R1", v, 2'b00, 1'(i % 2));
            check("R2", v, 2'b01, 1'(i % 2));
            check("R3", v, 2'b10, 1'b0);
            check("R7", v, 2'b10, 1'b1);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        operand = '0; kind = 2'b00; half = 1'b0;
        t_start();
        t_word_zeros();
        t_word_ones();
        t_word_sign();
        t_word_extremes();
        t_half_lanes();
        t_half_saturate();
        t_half_sign();
        t_reserved();
        t_no_clock();
        t_random();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule